// File: doc/BRIEF.md
# Random-Number Core Interrupt Aggregator

This block gathers the interrupt sources of a random-number core into one level-sensitive interrupt line, and does so in two stages. The first stage keeps three sticky event flags: generation done, data test fault and certification fault. It also holds a per-event enable mask. The enabled flags are combined into a single core interrupt bit, and that bit is recomputed, not latched, whenever the event control register is written or an event is accepted.

The second stage holds a two-bit pending register and a two-bit mask. The pending bits are the core interrupt at bit 0 and a bus slave error at bit 1. Both pending bits clear when a one is written to them. The mask cannot be written directly. Two write-only strobe registers change it: one clears mask bits and the other sets them. The irq output is a flop driven by the pending bits that are not masked.

Software reaches the block through a plain 32-bit register write port and a combinational read port. The random-number core drives one-cycle event pulses, together with a level that tells whether its entropy source is running.

Top module: `rng_irq_hub`

## Requirements
- R1: After reset the enables, the event flags and the pending bits are all zero, the mask reads 0x3 and irq is low.
- R2: A write to the event control register (byte offset 0x00) loads the enables from bits [2:0] (bit 0 done, bit 1 data test fault, bit 2 certification fault). A 1 in bits 5, 4 or 3 clears the flag of certification fault, data test fault or done respectively. The clear bits read back as zero.
- R3: A done pulse always sets flag bit 0 of the status register (offset 0x04). Data test fault and certification fault pulses set flag bits 1 and 2 only while src_enable is high, and are ignored otherwise.
- R4: Each event control write and each accepted event pulse recomputes pending bit 0 as the OR over the events of (flag AND enable), using the values in effect after that cycle. An event that arrives in the same cycle as its clear bit leaves the flag set.
- R5: The pending register (offset 0x10) clears each bit written as 1. A slave error pulse sets bit 1 and wins over a clear in the same cycle.
- R6: The mask (offset 0x14) resets to 0x3 and ignores direct writes.
- R7: A write to the unmask strobe (offset 0x18) clears the written mask bits. A write to the mask-set strobe (offset 0x1C) sets them. Both strobes read as zero.
- R8: irq is registered. It equals the OR of (pending AND NOT mask), and it takes its new value at the first clock edge after the write or event that caused the change.
- R9: The status register ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | DATA_W | Combinational read data |
| src_enable | input | 1 | Entropy source running |
| ev_done | input | 1 | Generation done pulse |
| ev_test_fault | input | 1 | Data test fault pulse |
| ev_cert_fault | input | 1 | Certification fault pulse |
| ev_slv_err | input | 1 | Slave error pulse |
| irq | output | 1 | Level interrupt |

## Verification
The bench drives fault pulses while the source is stopped. A design that ignored the gate would show those flags in the status register. It also drives a flag clear and the same event in one cycle, and a pending clear together with a slave error in one cycle. A design with the wrong priority would lose the event in either case. Mask traffic is checked through the two strobes and through a blocked direct write, so a design that inverted a strobe or let a direct write reach the mask would read back a wrong mask or raise irq at the wrong time. The core pending bit is checked after enables are switched on and off, which exposes a design that latches the bit instead of recomputing it.

// File: rtl/rng_irq_pkg.sv
// Shared constants for the interrupt aggregator: register offsets,
// event indices and bit positions that software decodes.
package rng_irq_pkg;
    localparam int NUM_EV   = 3;   // events of the first stage
    localparam int NUM_PEND = 2;   // pending bits of the second stage
    localparam int CLR_OFS  = 3;   // clear bits sit above the enables

    localparam int EV_DONE = 0;
    localparam int EV_TEST = 1;
    localparam int EV_CERT = 2;

    localparam int P_CORE = 0;
    localparam int P_SLV  = 1;

    localparam logic [7:0] A_EVT_CTRL = 8'h00;
    localparam logic [7:0] A_EVT_STAT = 8'h04;
    localparam logic [7:0] A_PEND     = 8'h10;
    localparam logic [7:0] A_MASK     = 8'h14;
    localparam logic [7:0] A_UNMASK   = 8'h18;
    localparam logic [7:0] A_SETMASK  = 8'h1C;
endpackage

// File: rtl/rng_evt_stage.sv
// First stage: sticky event flags, per-event enables and the core bit.
// Assumes event pulses are one cycle wide. Fault events need src_en;
// done does not. An event beats a clear of the same flag in one cycle.
module rng_evt_stage
    import rng_irq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ctrl_wr,
    input  logic [2*NUM_EV-1:0]   ctrl_data,
    input  logic                  src_en,
    input  logic [NUM_EV-1:0]     ev_pulse,
    output logic [NUM_EV-1:0]     en_q,
    output logic [NUM_EV-1:0]     flag_q,
    output logic                  core_nxt,
    output logic                  refresh
);
    logic [NUM_EV-1:0] accepted;
    logic [NUM_EV-1:0] flag_nxt;
    logic [NUM_EV-1:0] en_nxt;

    // Per event: gate by source state, then merge set and clear.
    for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
        if (i == EV_DONE) begin : g_ungated
            assign accepted[i] = ev_pulse[i];
        end else begin : g_gated
            assign accepted[i] = ev_pulse[i] & src_en;
        end
        assign flag_nxt[i] = accepted[i] |
                             (flag_q[i] & ~(ctrl_wr & ctrl_data[CLR_OFS+i]));
    end

    // Next enables and the recomputed core bit from next-state values.
    always_comb begin
        en_nxt   = ctrl_wr ? ctrl_data[NUM_EV-1:0] : en_q;
        core_nxt = |(flag_nxt & en_nxt);
        refresh  = ctrl_wr | (|accepted);
    end

    // State update for flags and enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            flag_q <= '0;
        end else begin
            en_q   <= en_nxt;
            flag_q <= flag_nxt;
        end
    end

    p_fault_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_en && !ctrl_wr) |=> (flag_q[EV_CERT:EV_TEST] == $past(flag_q[EV_CERT:EV_TEST])));
    p_done_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pulse[EV_DONE] |=> flag_q[EV_DONE]);
    p_clear_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_data[CLR_OFS+EV_DONE] && !ev_pulse[EV_DONE]) |=> !flag_q[EV_DONE]);
endmodule

// File: rtl/rng_pend_stage.sv
// Second stage: pending bits (write-one-to-clear), mask changed only
// through unmask and mask-set strobes, registered irq.
// Assumes at most one register write per cycle.
module rng_pend_stage
    import rng_irq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  refresh,
    input  logic                  core_nxt,
    input  logic                  slv_pulse,
    input  logic                  pend_wr,
    input  logic                  unmask_wr,
    input  logic                  setmask_wr,
    input  logic [NUM_PEND-1:0]   wdata,
    output logic [NUM_PEND-1:0]   pend_q,
    output logic [NUM_PEND-1:0]   mask_q,
    output logic                  irq
);
    logic [NUM_PEND-1:0] clr;
    logic [NUM_PEND-1:0] pend_nxt;
    logic [NUM_PEND-1:0] mask_nxt;

    // Next pending and mask values.
    always_comb begin
        clr              = pend_wr ? wdata : '0;
        pend_nxt[P_CORE] = refresh ? core_nxt : (pend_q[P_CORE] & ~clr[P_CORE]);
        pend_nxt[P_SLV]  = slv_pulse | (pend_q[P_SLV] & ~clr[P_SLV]);
        if (unmask_wr)       mask_nxt = mask_q & ~wdata;
        else if (setmask_wr) mask_nxt = mask_q | wdata;
        else                 mask_nxt = mask_q;
    end

    // Registers and the irq flop, fed from next-state values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            mask_q <= '1;
            irq    <= 1'b0;
        end else begin
            pend_q <= pend_nxt;
            mask_q <= mask_nxt;
            irq    <= |(pend_nxt & ~mask_nxt);
        end
    end

    p_slv_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        slv_pulse |=> pend_q[P_SLV]);
    p_unmask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        unmask_wr |=> ((mask_q & $past(wdata)) == '0));
    p_setmask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        setmask_wr |=> ((mask_q & $past(wdata)) == $past(wdata)));
    p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!unmask_wr && !setmask_wr) |=> $stable(mask_q));
    p_irq_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(pend_q & ~mask_q));
endmodule

// File: rtl/rng_irq_hub.sv
// Top: register decode, read mux and the two aggregation stages.
// Assumes word-aligned byte addresses; unmapped reads return zero.
module rng_irq_hub
    import rng_irq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              src_enable,
    input  logic              ev_done,
    input  logic              ev_test_fault,
    input  logic              ev_cert_fault,
    input  logic              ev_slv_err,
    output logic              irq
);
    logic [NUM_EV-1:0]   ev_pulse;
    logic [NUM_EV-1:0]   en_q;
    logic [NUM_EV-1:0]   flag_q;
    logic [NUM_PEND-1:0] pend_q;
    logic [NUM_PEND-1:0] mask_q;
    logic                core_nxt;
    logic                refresh;
    logic                ctrl_wr, pend_wr, unmask_wr, setmask_wr;
    logic                unused_wr_hi;

    // Write address decode and event bundling.
    always_comb begin
        ctrl_wr    = wr_en && (wr_addr == ADDR_W'(A_EVT_CTRL));
        pend_wr    = wr_en && (wr_addr == ADDR_W'(A_PEND));
        unmask_wr  = wr_en && (wr_addr == ADDR_W'(A_UNMASK));
        setmask_wr = wr_en && (wr_addr == ADDR_W'(A_SETMASK));
        ev_pulse           = '0;
        ev_pulse[EV_DONE]  = ev_done;
        ev_pulse[EV_TEST]  = ev_test_fault;
        ev_pulse[EV_CERT]  = ev_cert_fault;
    end
    assign unused_wr_hi = ^wr_data[DATA_W-1:2*NUM_EV];

    rng_evt_stage u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .ctrl_data (wr_data[2*NUM_EV-1:0]),
        .src_en    (src_enable),
        .ev_pulse  (ev_pulse),
        .en_q      (en_q),
        .flag_q    (flag_q),
        .core_nxt  (core_nxt),
        .refresh   (refresh)
    );

    rng_pend_stage u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .refresh    (refresh),
        .core_nxt   (core_nxt),
        .slv_pulse  (ev_slv_err),
        .pend_wr    (pend_wr),
        .unmask_wr  (unmask_wr),
        .setmask_wr (setmask_wr),
        .wdata      (wr_data[NUM_PEND-1:0]),
        .pend_q     (pend_q),
        .mask_q     (mask_q),
        .irq        (irq)
    );

    // Read mux; strobes and clear bits read as zero.
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(A_EVT_CTRL))      rd_data[NUM_EV-1:0]   = en_q;
        else if (rd_addr == ADDR_W'(A_EVT_STAT)) rd_data[NUM_EV-1:0]   = flag_q;
        else if (rd_addr == ADDR_W'(A_PEND))     rd_data[NUM_PEND-1:0] = pend_q;
        else if (rd_addr == ADDR_W'(A_MASK))     rd_data[NUM_PEND-1:0] = mask_q;
    end

    p_core_track_r4: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> (pend_q[P_CORE] == |(flag_q & en_q)));
endmodule

// File: tb/rng_irq_hub_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected values, a monitor pops
// and compares them one time step after each falling edge.
module rng_irq_hub_tb;
    localparam logic [7:0] A_CTRL = 8'h00, A_STAT = 8'h04, A_PEND = 8'h10,
                           A_MASK = 8'h14, A_UNM  = 8'h18, A_SETM = 8'h1C;
    localparam logic [7:0] K_IRQ = 8'hFF;

    typedef struct {
        logic [7:0]  addr;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0, rd_data;
    logic        src_enable = 1'b0;
    logic        ev_done = 1'b0, ev_test_fault = 1'b0, ev_cert_fault = 1'b0, ev_slv_err = 1'b0;
    logic        irq;
    item_t       sb[$];
    int          n_chk = 0, n_fail = 0;
    bit          finished = 1'b0;

    always #4 clk = ~clk;

    rng_irq_hub u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .src_enable(src_enable), .ev_done(ev_done), .ev_test_fault(ev_test_fault),
        .ev_cert_fault(ev_cert_fault), .ev_slv_err(ev_slv_err), .irq(irq)
    );

    // One bus/event cycle; ev = {slv, cert, test, done}.
    task automatic step(input bit we, input logic [7:0] a, input logic [31:0] d,
                        input logic [3:0] ev);
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d;
        {ev_slv_err, ev_cert_fault, ev_test_fault, ev_done} = ev;
        @(posedge clk); #1;
        wr_en = 1'b0;
        {ev_slv_err, ev_cert_fault, ev_test_fault, ev_done} = 4'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        step(1'b1, a, d, 4'b0);
    endtask

    task automatic pulse(input logic [3:0] ev);
        step(1'b0, 8'h00, 32'h0, ev);
    endtask

    task automatic exp_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        rd_addr = a;
        it.addr = a; it.exp = e; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic exp_irq(input logic e, input string tag);
        item_t it;
        @(negedge clk);
        it.addr = K_IRQ; it.exp = {31'b0, e}; it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: compare queued expectations away from the clock edge.
    initial begin
        forever begin
            @(negedge clk); #1;
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = sb.pop_front();
                act = (it.addr == K_IRQ) ? {31'b0, irq} : rd_data;
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual 0x%0h expected 0x%0h", it.tag, act, it.exp);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        exp_irq(1'b0, "R1 irq");
        exp_rd(A_CTRL, 32'h0, "R1 enables");
        exp_rd(A_STAT, 32'h0, "R1 flags");
        exp_rd(A_PEND, 32'h0, "R1 pending");
        exp_rd(A_MASK, 32'h3, "R1 mask");
        // R6 direct mask write ignored, R9 status write ignored
        wr(A_MASK, 32'h0);
        exp_rd(A_MASK, 32'h3, "R6 mask write blocked");
        pulse(4'b0001);
        wr(A_STAT, 32'h0);
        exp_rd(A_STAT, 32'h1, "R9 status write ignored");
        wr(A_CTRL, 32'h08);
        // R3 faults ignored with source stopped, even when enabled
        wr(A_CTRL, 32'h07);
        pulse(4'b0110);
        exp_rd(A_STAT, 32'h0, "R3 gated faults");
        exp_rd(A_PEND, 32'h0, "R3 no core bit");
        wr(A_CTRL, 32'h00);
        pulse(4'b0001);
        exp_rd(A_STAT, 32'h1, "R3 done ungated");
        exp_rd(A_PEND, 32'h0, "R4 disabled event");
        // R2/R4 enable done -> core bit recomputed, masked irq
        wr(A_CTRL, 32'h01);
        exp_rd(A_CTRL, 32'h1, "R2 enable readback");
        exp_rd(A_PEND, 32'h1, "R4 core bit on enable");
        exp_irq(1'b0, "R8 masked");
        // R7 unmask core, R8 irq in the first cycle
        wr(A_UNM, 32'h1);
        exp_irq(1'b1, "R8 irq after unmask");
        exp_rd(A_MASK, 32'h2, "R7 unmask");
        exp_rd(A_UNM, 32'h0, "R7 unmask reads zero");
        // R5 write-one-to-clear of core bit
        wr(A_PEND, 32'h1);
        exp_irq(1'b0, "R5 irq after clear");
        exp_rd(A_PEND, 32'h0, "R5 core cleared");
        exp_rd(A_STAT, 32'h1, "R5 flag untouched");
        // R2 clear done flag, enable kept
        wr(A_CTRL, 32'h09);
        exp_rd(A_STAT, 32'h0, "R2 done cleared");
        exp_rd(A_CTRL, 32'h1, "R2 clear bits read zero");
        // R3 faults pass with source running
        src_enable = 1'b1;
        pulse(4'b0100);
        exp_rd(A_STAT, 32'h4, "R3 cert flag");
        exp_rd(A_PEND, 32'h0, "R4 cert not enabled");
        wr(A_CTRL, 32'h04);
        exp_irq(1'b1, "R8 irq from cert");
        exp_rd(A_PEND, 32'h1, "R4 cert enabled");
        pulse(4'b0010);
        exp_rd(A_STAT, 32'h6, "R3 test flag");
        // R4 event beats clear in the same cycle
        step(1'b1, A_CTRL, 32'h14, 4'b0010);
        exp_rd(A_STAT, 32'h6, "R4 event beats clear");
        // R4 recompute to zero when enables drop
        wr(A_CTRL, 32'h20);
        exp_rd(A_STAT, 32'h2, "R2 cert cleared");
        exp_rd(A_PEND, 32'h0, "R4 core recomputed low");
        exp_irq(1'b0, "R8 irq low");
        // R5/R7 slave error path
        pulse(4'b1000);
        exp_rd(A_PEND, 32'h2, "R5 slave error set");
        exp_irq(1'b0, "R8 slave masked");
        wr(A_UNM, 32'h2);
        exp_irq(1'b1, "R8 slave unmasked");
        exp_rd(A_MASK, 32'h0, "R7 both unmasked");
        wr(A_SETM, 32'h2);
        exp_irq(1'b0, "R7 irq after mask set");
        exp_rd(A_MASK, 32'h2, "R7 mask set");
        exp_rd(A_SETM, 32'h0, "R7 mask-set reads zero");
        wr(A_UNM, 32'h2);
        step(1'b1, A_PEND, 32'h2, 4'b1000);
        exp_rd(A_PEND, 32'h2, "R5 set beats clear");
        exp_irq(1'b1, "R8 irq held");
        wr(A_PEND, 32'h2);
        exp_rd(A_PEND, 32'h0, "R5 slave cleared");
        exp_irq(1'b0, "R8 irq dropped");
        @(negedge clk); #2;
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule